// File: doc/BRIEF.md
# Legacy System I/O Control Register Block

This block sits on a byte-wide, port-mapped I/O bus and answers one-byte reads and writes at a handful of fixed 16-bit port addresses. It holds a soft-reset control port, a masked system-control register and an I/O-map-type register whose stored bit drives a dedicated output. It also returns strap-set equipment and board-identification bytes, a keylock byte that always reads zero, and a set of write-only ports whose writes are taken and dropped.

Bits inside every register are numbered from the most significant end: bit number n has the mask `1 << (7 - n)`, so bit 7 is the least significant bit. A request to switch the processor to little-endian byte order cannot be honoured. It sets a sticky error flag and is never stored.

A separate 4-byte memory-mapped window returns a zero parity-error status word. It only accepts full 32-bit reads, and a narrower read gets a bus error.

Top module: `sysio_regblk`

## Requirements
- R1: A write to port 0x092 stores only bit 7 (value 0x01). Reads of 0x092 return the stored byte, and `soft_reset_o` equals the stored bit from the clock edge that takes the write.
- R2: A write to port 0x092 with bit 6 (value 0x02) set raises `le_unsup_o`, which stays high until reset. That bit is never stored, so it reads back as 0.
- R3: A write to port 0x81C keeps only bits 0 to 3 (mask 0xF0). Reads return the kept bits, and every other bit reads as zero.
- R4: A write to port 0x850 keeps only bit 7 (value 0x01). Reads return the stored byte, `noncontig_map_o` equals the stored bit, and the output changes only on a write to 0x850.
- R5: After synchronous reset, 0x092 reads 0x00, 0x81C reads 0x00 and 0x850 reads 0x01. `noncontig_map_o` is 1, and `soft_reset_o` and `le_unsup_o` are 0.
- R6: Port 0x80C returns `equip_strap` and port 0x852 returns `board_id_strap`. Writes to these ports have no effect.
- R7: Port 0x818 always reads 0x00, and writes to it have no effect.
- R8: Reads of the write-only ports 0x808, 0x810, 0x812 and 0x814, and of any unmapped port, return 0xFF. Writes to them leave every stored register unchanged.
- R9: `io_rdata` takes the addressed byte at the clock edge where `io_rd` is high. It holds that value until the next read.
- R10: A read of the window at 0xBFFFEFF0 (the low two address bits are ignored) with `mm_be` = 4'b1111 gives a one-cycle `mm_ack` with `mm_rdata` = 0 and `mm_err` = 0.
- R11: A window read with any other `mm_be` gives `mm_ack` together with `mm_err` for one cycle. A read outside the window gives neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 16 | I/O port address |
| io_wdata | input | 8 | I/O write byte |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_rdata | output | 8 | Registered I/O read byte |
| equip_strap | input | 8 | Equipment byte returned at 0x80C |
| board_id_strap | input | 8 | Board-identification byte returned at 0x852 |
| mm_rd | input | 1 | Memory-mapped read strobe |
| mm_addr | input | 32 | Memory-mapped byte address |
| mm_be | input | 4 | Byte enables of the memory-mapped read |
| mm_rdata | output | 32 | Memory-mapped read data |
| mm_ack | output | 1 | Window access answered |
| mm_err | output | 1 | Window access was not a full word |
| soft_reset_o | output | 1 | Soft-reset request to the processor |
| noncontig_map_o | output | 1 | Non-contiguous I/O map select |
| le_unsup_o | output | 1 | Sticky unsupported little-endian request |

## Verification
The assertions assume that `io_rd` and `io_wr` are never high in the same cycle. They also assume that the straps stay still while the bench reads them, since the read byte is checked against the strap value one cycle later. The bench drives each bus operation as one strobe cycle with both strobes low around it, and it holds the straps constant for the whole run. The only time the straps could change is the reset that is applied again for the sticky-flag test, when no read is in flight.

// File: rtl/sysio_pkg.sv
package sysio_pkg;

    localparam int BYTE_W = 8;

    // bit number n is the mask 1 << (7 - n)
    function automatic logic [BYTE_W-1:0] bitn(input int n);
        return 8'(1) << (BYTE_W - 1 - n);
    endfunction

    localparam logic [15:0] A_SRST    = 16'h0092;
    localparam logic [15:0] A_LAMP    = 16'h0808;
    localparam logic [15:0] A_EQUIP   = 16'h080C;
    localparam logic [15:0] A_PWD1    = 16'h0810;
    localparam logic [15:0] A_PWD2    = 16'h0812;
    localparam logic [15:0] A_L2INV   = 16'h0814;
    localparam logic [15:0] A_KEYLOCK = 16'h0818;
    localparam logic [15:0] A_SYSCTL  = 16'h081C;
    localparam logic [15:0] A_MAPTYPE = 16'h0850;
    localparam logic [15:0] A_BOARDID = 16'h0852;

    localparam logic [BYTE_W-1:0] SRST_MASK   = bitn(7);
    localparam logic [BYTE_W-1:0] LE_MASK     = bitn(6);
    localparam logic [BYTE_W-1:0] SYSCTL_MASK = bitn(0) | bitn(1) | bitn(2) | bitn(3);
    localparam logic [BYTE_W-1:0] MAP_MASK    = bitn(7);
    localparam logic [BYTE_W-1:0] KEYLOCK_VAL = '0;
    localparam logic [BYTE_W-1:0] FLOAT_VAL   = '1;

    typedef enum logic [2:0] {
        P_SRST, P_EQUIP, P_SYSCTL, P_MAPTYPE,
        P_BOARDID, P_KEYLOCK, P_WONLY, P_NONE
    } port_e;

    typedef struct packed {
        logic [BYTE_W-1:0] srst;
        logic [BYTE_W-1:0] sysctl;
        logic [BYTE_W-1:0] maptype;
        logic              le_err;
    } ctrl_state_t;

    function automatic port_e decode_port(input logic [15:0] a);
        case (a)
            A_SRST:    return P_SRST;
            A_EQUIP:   return P_EQUIP;
            A_SYSCTL:  return P_SYSCTL;
            A_MAPTYPE: return P_MAPTYPE;
            A_BOARDID: return P_BOARDID;
            A_KEYLOCK: return P_KEYLOCK;
            A_LAMP, A_PWD1, A_PWD2, A_L2INV: return P_WONLY;
            default:   return P_NONE;
        endcase
    endfunction

endpackage

// File: rtl/sysio_decode.sv
module sysio_decode
    import sysio_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    output port_e             sel
);
    localparam int PAD_W = (ADDR_W < 16) ? 16 - ADDR_W : 0;

    logic [15:0] addr16;

    generate
        if (ADDR_W >= 16) begin : g_wide
            // upper bits beyond the port space must be zero to hit a port
            logic hi_zero;
            if (ADDR_W > 16) begin : g_hi
                assign hi_zero = (addr[ADDR_W-1:16] == '0);
            end else begin : g_nohi
                assign hi_zero = 1'b1;
            end
            assign addr16 = hi_zero ? addr[15:0] : 16'hFFFF;
        end else begin : g_narrow
            assign addr16 = {{PAD_W{1'b0}}, addr};
        end
    endgenerate

    always_comb sel = decode_port(addr16);

endmodule

// File: rtl/sysio_ctrl_regs.sv
module sysio_ctrl_regs
    import sysio_pkg::*;
#(
    parameter logic [7:0] MAP_RST_VAL = 8'h01
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  port_e       sel,
    input  logic [7:0]  wdata,
    output ctrl_state_t st
);
    ctrl_state_t st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.srst    <= '0;
            st_q.sysctl  <= '0;
            st_q.maptype <= MAP_RST_VAL & MAP_MASK;
            st_q.le_err  <= 1'b0;
        end else if (wr_en) begin
            case (sel)
                P_SRST: begin
                    st_q.srst <= wdata & SRST_MASK;
                    if ((wdata & LE_MASK) != '0) begin
                        st_q.le_err <= 1'b1;
                    end
                end
                P_SYSCTL:  st_q.sysctl  <= wdata & SYSCTL_MASK;
                P_MAPTYPE: st_q.maptype <= wdata & MAP_MASK;
                default: ;
            endcase
        end
    end

    assign st = st_q;

endmodule

// File: rtl/sysio_rd_mux.sv
module sysio_rd_mux
    import sysio_pkg::*;
(
    input  port_e       sel,
    input  ctrl_state_t st,
    input  logic [7:0]  equip,
    input  logic [7:0]  board_id,
    output logic [7:0]  rbyte
);
    always_comb begin
        case (sel)
            P_SRST:    rbyte = st.srst;
            P_EQUIP:   rbyte = equip;
            P_SYSCTL:  rbyte = st.sysctl;
            P_MAPTYPE: rbyte = st.maptype;
            P_BOARDID: rbyte = board_id;
            P_KEYLOCK: rbyte = KEYLOCK_VAL;
            default:   rbyte = FLOAT_VAL;
        endcase
    end
endmodule

// File: rtl/sysio_parity_win.sv
module sysio_parity_win #(
    parameter logic [31:0] BASE   = 32'hBFFF_EFF0,
    parameter int          BE_W   = 4,
    parameter int          DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd,
    input  logic [31:0]       addr,
    input  logic [BE_W-1:0]   be,
    output logic [DATA_W-1:0] rdata,
    output logic              ack,
    output logic              err
);
    localparam logic [31:0] WORD_MASK = ~32'(BE_W - 1);

    logic in_win;
    logic full_word;

    assign in_win    = (addr & WORD_MASK) == (BASE & WORD_MASK);
    assign full_word = &be;

    always_ff @(posedge clk) begin
        if (rst) begin
            ack   <= 1'b0;
            err   <= 1'b0;
            rdata <= '0;
        end else begin
            ack   <= rd && in_win;
            err   <= rd && in_win && !full_word;
            rdata <= '0;
        end
    end
endmodule

// File: rtl/sysio_regblk.sv
module sysio_regblk
    import sysio_pkg::*;
#(
    parameter int          ADDR_W      = 16,
    parameter logic [7:0]  MAP_RST_VAL = 8'h01,
    parameter logic [31:0] WIN_BASE    = 32'hBFFF_EFF0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [7:0]        io_wdata,
    input  logic              io_wr,
    input  logic              io_rd,
    output logic [7:0]        io_rdata,
    input  logic [7:0]        equip_strap,
    input  logic [7:0]        board_id_strap,
    input  logic              mm_rd,
    input  logic [31:0]       mm_addr,
    input  logic [3:0]        mm_be,
    output logic [31:0]       mm_rdata,
    output logic              mm_ack,
    output logic              mm_err,
    output logic              soft_reset_o,
    output logic              noncontig_map_o,
    output logic              le_unsup_o
);
    port_e       sel;
    ctrl_state_t st;
    logic [7:0]  rbyte;
    logic [7:0]  rdata_q;

    sysio_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (io_addr),
        .sel  (sel)
    );

    sysio_ctrl_regs #(.MAP_RST_VAL(MAP_RST_VAL)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr_en (io_wr),
        .sel   (sel),
        .wdata (io_wdata),
        .st    (st)
    );

    sysio_rd_mux u_mux (
        .sel      (sel),
        .st       (st),
        .equip    (equip_strap),
        .board_id (board_id_strap),
        .rbyte    (rbyte)
    );

    sysio_parity_win #(.BASE(WIN_BASE), .BE_W(4), .DATA_W(32)) u_win (
        .clk   (clk),
        .rst   (rst),
        .rd    (mm_rd),
        .addr  (mm_addr),
        .be    (mm_be),
        .rdata (mm_rdata),
        .ack   (mm_ack),
        .err   (mm_err)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (io_rd) begin
            rdata_q <= rbyte;
        end
    end

    assign io_rdata        = rdata_q;
    assign soft_reset_o    = |(st.srst & SRST_MASK);
    assign noncontig_map_o = |(st.maptype & MAP_MASK);
    assign le_unsup_o      = st.le_err;

endmodule

// File: rtl/sysio_regblk_chk.sv
module sysio_regblk_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] io_addr,
    input logic [7:0]        io_wdata,
    input logic              io_wr,
    input logic              io_rd,
    input logic [7:0]        io_rdata,
    input logic              mm_rd,
    input logic [31:0]       mm_addr,
    input logic [3:0]        mm_be,
    input logic [31:0]       mm_rdata,
    input logic              mm_ack,
    input logic              mm_err,
    input logic              soft_reset_o,
    input logic              noncontig_map_o,
    input logic              le_unsup_o
);
    logic hit_srst, hit_map, hit_key, in_win;
    assign hit_srst = io_addr == ADDR_W'(16'h0092);
    assign hit_map  = io_addr == ADDR_W'(16'h0850);
    assign hit_key  = io_addr == ADDR_W'(16'h0818);
    assign in_win   = mm_addr[31:2] == 30'h2FFF_FBFC;

    // R1
    srst_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (io_wr && hit_srst) |=> (soft_reset_o == $past(io_wdata[0])));

    // R2
    le_raise_chk: assert property (@(posedge clk) disable iff (rst)
        (io_wr && hit_srst && io_wdata[1]) |=> le_unsup_o);

    // R2
    le_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        le_unsup_o |=> le_unsup_o);

    // R4
    map_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (io_wr && hit_map) |=> (noncontig_map_o == $past(io_wdata[0])));

    // R4
    map_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(io_wr && hit_map) |=> $stable(noncontig_map_o));

    // R7
    keylock_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (io_rd && hit_key) |=> (io_rdata == 8'h00));

    // R9
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !io_rd |=> $stable(io_rdata));

    // R10
    win_zero_chk: assert property (@(posedge clk) disable iff (rst)
        mm_ack |-> (mm_rdata == 32'h0));

    // R11
    win_err_chk: assert property (@(posedge clk) disable iff (rst)
        (mm_rd && in_win && (mm_be != 4'hF)) |=> (mm_ack && mm_err));

    // R11
    win_miss_chk: assert property (@(posedge clk) disable iff (rst)
        (mm_rd && !in_win) |=> (!mm_ack && !mm_err));
endmodule

bind sysio_regblk sysio_regblk_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .io_addr         (io_addr),
    .io_wdata        (io_wdata),
    .io_wr           (io_wr),
    .io_rd           (io_rd),
    .io_rdata        (io_rdata),
    .mm_rd           (mm_rd),
    .mm_addr         (mm_addr),
    .mm_be           (mm_be),
    .mm_rdata        (mm_rdata),
    .mm_ack          (mm_ack),
    .mm_err          (mm_err),
    .soft_reset_o    (soft_reset_o),
    .noncontig_map_o (noncontig_map_o),
    .le_unsup_o      (le_unsup_o)
);

// File: tb/sim_sysio_regblk.sv
`timescale 1ns/1ps
module sim_sysio_regblk;
    localparam logic [7:0] EQUIP = 8'hA5;
    localparam logic [7:0] BID   = 8'h3C;
    localparam int NV = 31;
    // {op(1=read), req, addr, wdata, expected}
    localparam logic [36:0] VEC [NV] = '{
        {1'b0,4'd1,16'h0092,8'h01,8'h00}, {1'b1,4'd1,16'h0092,8'h00,8'h01},  // R1
        {1'b0,4'd1,16'h0092,8'hFD,8'h00}, {1'b1,4'd1,16'h0092,8'h00,8'h01},  // R1
        {1'b0,4'd1,16'h0092,8'h00,8'h00}, {1'b1,4'd1,16'h0092,8'h00,8'h00},  // R1
        {1'b0,4'd3,16'h081C,8'hFF,8'h00}, {1'b1,4'd3,16'h081C,8'h00,8'hF0},  // R3
        {1'b0,4'd3,16'h081C,8'h5A,8'h00}, {1'b1,4'd3,16'h081C,8'h00,8'h50},  // R3
        {1'b0,4'd4,16'h0850,8'h00,8'h00}, {1'b1,4'd4,16'h0850,8'h00,8'h00},  // R4
        {1'b0,4'd4,16'h0850,8'hFE,8'h00}, {1'b1,4'd4,16'h0850,8'h00,8'h00},  // R4
        {1'b0,4'd4,16'h0850,8'h03,8'h00}, {1'b1,4'd4,16'h0850,8'h00,8'h01},  // R4
        {1'b1,4'd6,16'h080C,8'h00,EQUIP}, {1'b0,4'd6,16'h080C,8'h00,8'h00},  // R6
        {1'b1,4'd6,16'h080C,8'h00,EQUIP}, {1'b1,4'd6,16'h0852,8'h00,BID},    // R6
        {1'b1,4'd7,16'h0818,8'h00,8'h00}, {1'b0,4'd7,16'h0818,8'hFF,8'h00},  // R7
        {1'b1,4'd7,16'h0818,8'h00,8'h00},                                    // R7
        {1'b0,4'd8,16'h0808,8'hFF,8'h00}, {1'b0,4'd8,16'h0810,8'h00,8'h00},  // R8
        {1'b0,4'd8,16'h0812,8'hAA,8'h00}, {1'b0,4'd8,16'h0814,8'h01,8'h00},  // R8
        {1'b1,4'd8,16'h0810,8'h00,8'hFF}, {1'b1,4'd8,16'h0123,8'h00,8'hFF},  // R8
        {1'b1,4'd8,16'h081C,8'h00,8'h50}, {1'b1,4'd8,16'h0850,8'h00,8'h01}   // R8
    };

    logic clk = 0, rst = 1;
    logic [15:0] io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic io_wr = 0, io_rd = 0;
    logic [7:0]  io_rdata;
    logic mm_rd = 0;
    logic [31:0] mm_addr = '0;
    logic [3:0]  mm_be = '0;
    logic [31:0] mm_rdata;
    logic mm_ack, mm_err, soft_reset_o, noncontig_map_o, le_unsup_o;
    int checks = 0, errors = 0;
    logic done = 0;

    always #2.5 clk = ~clk;

    sysio_regblk u0 (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata),
        .equip_strap(EQUIP), .board_id_strap(BID),
        .mm_rd(mm_rd), .mm_addr(mm_addr), .mm_be(mm_be),
        .mm_rdata(mm_rdata), .mm_ack(mm_ack), .mm_err(mm_err),
        .soft_reset_o(soft_reset_o), .noncontig_map_o(noncontig_map_o),
        .le_unsup_o(le_unsup_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1;
        @(negedge clk); @(negedge clk); rst = 0;
    endtask

    task automatic io_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1;
        @(negedge clk); io_wr = 0;
    endtask

    task automatic io_read(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk); io_addr = a; io_rd = 1;
        @(negedge clk); io_rd = 0; d = io_rdata;
    endtask

    task automatic mm_read(input logic [31:0] a, input logic [3:0] be);
        @(negedge clk); mm_addr = a; mm_be = be; mm_rd = 1;
        @(negedge clk); mm_rd = 0;
    endtask

    initial begin
        logic [7:0] rb;
        do_reset();
        // R5 reset state
        chk("R5 soft", {31'b0, soft_reset_o}, 0);
        chk("R5 map", {31'b0, noncontig_map_o}, 1);
        chk("R5 le", {31'b0, le_unsup_o}, 0);
        io_read(16'h0092, rb); chk("R5 0x092", {24'b0, rb}, 32'h00);
        io_read(16'h081C, rb); chk("R5 0x81C", {24'b0, rb}, 32'h00);
        io_read(16'h0850, rb); chk("R5 0x850", {24'b0, rb}, 32'h01);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][36]) begin
                io_read(VEC[i][31:16], rb);
                chk($sformatf("R%0d vec %0d", VEC[i][35:32], i), {24'b0, rb}, {24'b0, VEC[i][7:0]});
            end else begin
                io_write(VEC[i][31:16], VEC[i][15:8]);
            end
        end

        // R1 output follows stored bit
        io_write(16'h0092, 8'h01); chk("R1 soft set", {31'b0, soft_reset_o}, 1);
        io_write(16'h0092, 8'hFE); chk("R1 soft clr", {31'b0, soft_reset_o}, 0);
        chk("R2 le after 0xFE", {31'b0, le_unsup_o}, 1);
        do_reset();
        chk("R5 le cleared", {31'b0, le_unsup_o}, 0);
        // R2 little-endian request
        io_write(16'h0092, 8'h03);
        chk("R2 le set", {31'b0, le_unsup_o}, 1);
        io_read(16'h0092, rb); chk("R2 not stored", {24'b0, rb}, 32'h01);
        io_write(16'h0092, 8'h00);
        chk("R2 sticky", {31'b0, le_unsup_o}, 1);
        // R4 output
        io_write(16'h0850, 8'h00); chk("R4 map low", {31'b0, noncontig_map_o}, 0);
        io_write(16'h081C, 8'hFF); chk("R4 map hold", {31'b0, noncontig_map_o}, 0);
        io_write(16'h0850, 8'h01); chk("R4 map high", {31'b0, noncontig_map_o}, 1);
        // R9 hold between reads
        io_read(16'h0852, rb);
        io_write(16'h0092, 8'h01);
        @(negedge clk); chk("R9 hold", {24'b0, io_rdata}, {24'b0, BID});
        // R10 / R11 window
        mm_read(32'hBFFF_EFF0, 4'hF);
        chk("R10 ack", {31'b0, mm_ack}, 1); chk("R10 err", {31'b0, mm_err}, 0);
        chk("R10 data", mm_rdata, 0);
        @(negedge clk); chk("R10 pulse", {31'b0, mm_ack}, 0);
        mm_read(32'hBFFF_EFF2, 4'h3);
        chk("R11 ack", {31'b0, mm_ack}, 1); chk("R11 err", {31'b0, mm_err}, 1);
        mm_read(32'hBFFF_EFF4, 4'hF);
        chk("R11 miss ack", {31'b0, mm_ack}, 0); chk("R11 miss err", {31'b0, mm_err}, 0);
        done = 1;
    end

    initial begin
        for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual hung expected done");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule